// File: doc/BRIEF.md
# Event Readout Master with Chained Bus Ownership

This block collects variable-length event records from a client, holds them in a local buffer, and unloads one record per load cycle onto a crate-wide shared bus. A central processor broadcasts a load command to every board in the crate. Each board waits for its own programmed delay after that command, so that boards rarely contend for the bus. Once a complete record sits in the buffer, the board raises a bus request. It then waits for the ownership token, which arrives from the board upstream in the chain. When it holds the token, the board sends a header word carrying its event counter, followed by the record's words as one unbroken burst. It then gives up the bus and raises its done flag.

The client side is a valid/ready stream. A word is taken on any cycle where `in_valid` and `in_ready` are both high. `in_ready` falls only when the buffer is full, and the client must then hold the word until it is taken. The bus side has no back-pressure: a burst, once started, emits one word per cycle. A watchdog limits how long the board waits for the end-of-event marker. A single-word slave read lets the processor pull words directly while the board is idle.

Top module: `evt_unload_master`

## Requirements
- R1: The input buffer holds DEPTH words, in arrival order. `in_ready` is low exactly when it holds DEPTH words, and no accepted word is lost or reordered.
- R2: A `start_load` sampled while the board is idle clears `done` and `err`. A `start_load` sampled while a load cycle is in progress has no effect.
- R3: After an accepted `start_load`, the board waits `delay_cfg`+1 cycles before it begins looking for data. `bus_req` therefore cannot rise earlier than `delay_cfg`+2 cycles after that command.
- R4: `bus_req` rises only once a word flagged with `in_eoe`=1 (the end-of-event marker) is in the buffer, or once the marker watchdog has expired. It stays high until the last word of the burst has been sent.
- R5: `grant_out` equals `grant_in` while `bus_req` is low, and is 0 while `bus_req` is high.
- R6: In the cycle after `grant_in` is sampled high with `bus_req` high, the board drives a header word. The header is the event counter, zero-extended into bit 0 upward. The buffered words follow one per cycle, with `bus_valid` high throughout. `bus_last` marks the end-of-event marker word, which is itself sent.
- R7: In the cycle after the last burst word, `bus_req` is low and `done` is high. `done` stays high until the next accepted `start_load`.
- R8: Looking for data lasts at most `timeout_cfg`+1 cycles. If no marker is buffered by then, the burst is the header word alone, with `bus_last` high. `err` rises together with `done`, and the buffered words are left in place.
- R9: The event counter starts at 0 after reset. It increases by one, modulo 2^CNT_W, after every burst, including bursts that end on a timeout.
- R10: A `slv_rd` sampled while the board is idle and `start_load` is low produces `slv_rvalid`=1 in the next cycle. `slv_rdata` then holds the oldest buffered word, which is removed, or 0 if the buffer is empty. In every other case `slv_rvalid` and `slv_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Client word valid |
| in_ready | output | 1 | Buffer can accept a word |
| in_data | input | DATA_W | Client word |
| in_eoe | input | 1 | Word is the end-of-event marker |
| start_load | input | 1 | Load command from the processor (one-cycle pulse) |
| delay_cfg | input | DELAY_W | Per-board wait after the load command |
| timeout_cfg | input | TMO_W | Marker watchdog limit in cycles |
| bus_req | output | 1 | Bus ownership request, held while owning |
| grant_in | input | 1 | Ownership token from upstream |
| grant_out | output | 1 | Ownership token to downstream |
| bus_valid | output | 1 | Bus word driven this cycle |
| bus_data | output | DATA_W | Bus word |
| bus_last | output | 1 | Final word of the burst |
| done | output | 1 | Module-done flag |
| err | output | 1 | Last burst ended on watchdog expiry |
| slv_rd | input | 1 | Slave single-word read strobe |
| slv_rvalid | output | 1 | Slave read data valid |
| slv_rdata | output | DATA_W | Slave read data |

## Verification
The embedded properties are checked on every cycle. They cover the following: the buffer is never popped when empty, and a header word only follows a sampled grant. The token is never passed downstream while a word is on the bus, and the request only falls right after a last word. `done` holds between commands, `err` rises only from a timed-out header, and the counter steps once per burst. The exact delay and watchdog cycle counts, the header values, and word order across buffer wrap and full conditions can only be shown by the bench's scenarios. The same holds for commands ignored while busy and for slave reads of marker and empty entries.

// File: rtl/evt_unload_pkg.sv
package evt_unload_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DELAY,
    ST_WAIT,
    ST_REQ,
    ST_HDR,
    ST_BURST
  } seq_state_t;
endpackage

// File: rtl/evt_fifo.sv
module evt_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_eoe,
  output logic              wr_ready,
  input  logic              rd_pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_eoe,
  output logic              empty,
  output logic              has_marker
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  logic [DATA_W:0] mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [CW-1:0]   cnt, mcnt;
  logic            push;

  assign wr_ready   = (cnt != CNT_FULL);
  assign push       = wr_valid && wr_ready;
  assign empty      = (cnt == '0);
  assign has_marker = (mcnt != '0);
  assign rd_data    = mem[rp][DATA_W-1:0];
  assign rd_eoe     = mem[rp][DATA_W];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {wr_eoe, wr_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      cnt  <= '0;
      mcnt <= '0;
    end else begin
      if (push)   wp <= (wp == PTR_LAST) ? '0 : wp + 1'b1;
      if (rd_pop) rp <= (rp == PTR_LAST) ? '0 : rp + 1'b1;
      cnt  <= cnt + CW'(push) - CW'(rd_pop);
      mcnt <= mcnt + CW'(push && wr_eoe) - CW'(rd_pop && rd_eoe);
    end
  end

  assert_no_underflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop |-> !empty);
endmodule

// File: rtl/evt_seq.sv
module evt_seq
  import evt_unload_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DELAY_W = 8,
  parameter int TMO_W   = 8,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_load,
  input  logic [DELAY_W-1:0] delay_cfg,
  input  logic [TMO_W-1:0]   timeout_cfg,
  input  logic               has_marker,
  input  logic               fifo_empty,
  input  logic [DATA_W-1:0]  head_data,
  input  logic               head_eoe,
  input  logic               grant_in,
  input  logic               slv_rd,
  output logic               pop,
  output logic               bus_req,
  output logic               bus_valid,
  output logic [DATA_W-1:0]  bus_data,
  output logic               bus_last,
  output logic               done,
  output logic               err,
  output logic               slv_rvalid,
  output logic [DATA_W-1:0]  slv_rdata
);
  seq_state_t         state;
  logic [DELAY_W-1:0] dcnt;
  logic [TMO_W-1:0]   tcnt;
  logic               tmo;
  logic [CNT_W-1:0]   evt_cnt;
  logic               slv_ok, finish;

  assign slv_ok    = slv_rd && (state == ST_IDLE) && !start_load;
  assign pop       = (state == ST_BURST) || (slv_ok && !fifo_empty);
  assign bus_req   = (state == ST_REQ) || (state == ST_HDR) || (state == ST_BURST);
  assign bus_valid = (state == ST_HDR) || (state == ST_BURST);
  assign bus_data  = (state == ST_HDR) ? DATA_W'(evt_cnt) : head_data;
  assign bus_last  = ((state == ST_HDR) && tmo) || ((state == ST_BURST) && head_eoe);
  assign finish    = bus_valid && bus_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      dcnt       <= '0;
      tcnt       <= '0;
      tmo        <= 1'b0;
      evt_cnt    <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
      slv_rvalid <= 1'b0;
      slv_rdata  <= '0;
    end else begin
      slv_rvalid <= slv_ok;
      slv_rdata  <= (slv_ok && !fifo_empty) ? head_data : '0;
      unique case (state)
        ST_IDLE: if (start_load) begin
          done  <= 1'b0;
          err   <= 1'b0;
          dcnt  <= delay_cfg;
          state <= ST_DELAY;
        end
        ST_DELAY: if (dcnt == '0) begin
          tcnt  <= '0;
          state <= ST_WAIT;
        end else begin
          dcnt <= dcnt - 1'b1;
        end
        ST_WAIT: if (has_marker) begin
          tmo   <= 1'b0;
          state <= ST_REQ;
        end else if (tcnt == timeout_cfg) begin
          tmo   <= 1'b1;
          state <= ST_REQ;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
        ST_REQ:   if (grant_in) state <= ST_HDR;
        ST_HDR:   if (!tmo) state <= ST_BURST;
        ST_BURST: ;
        default:  state <= ST_IDLE;
      endcase
      if (finish) begin
        state   <= ST_IDLE;
        done    <= 1'b1;
        err     <= tmo;
        evt_cnt <= evt_cnt + 1'b1;
      end
    end
  end

  assert_hdr_after_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HDR) |-> $past(grant_in && state == ST_REQ));
  assert_req_drop_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> $past(bus_valid && bus_last));
  assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start_load) |=> done);
  assert_err_from_timeout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(state == ST_HDR && tmo));
  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_last) |=> (evt_cnt == $past(evt_cnt) + 1'b1));
  assert_slave_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    slv_rvalid |-> $past(slv_rd));
endmodule

// File: rtl/evt_unload_master.sv
module evt_unload_master #(
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 16,
  parameter int DELAY_W = 8,
  parameter int TMO_W   = 8,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_data,
  input  logic               in_eoe,
  input  logic               start_load,
  input  logic [DELAY_W-1:0] delay_cfg,
  input  logic [TMO_W-1:0]   timeout_cfg,
  output logic               bus_req,
  input  logic               grant_in,
  output logic               grant_out,
  output logic               bus_valid,
  output logic [DATA_W-1:0]  bus_data,
  output logic               bus_last,
  output logic               done,
  output logic               err,
  input  logic               slv_rd,
  output logic               slv_rvalid,
  output logic [DATA_W-1:0]  slv_rdata
);
  logic              pop, empty, has_marker, head_eoe;
  logic [DATA_W-1:0] head_data;

  evt_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(in_valid), .wr_data(in_data), .wr_eoe(in_eoe), .wr_ready(in_ready),
    .rd_pop(pop), .rd_data(head_data), .rd_eoe(head_eoe),
    .empty(empty), .has_marker(has_marker)
  );

  evt_seq #(.DATA_W(DATA_W), .DELAY_W(DELAY_W), .TMO_W(TMO_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_load(start_load), .delay_cfg(delay_cfg), .timeout_cfg(timeout_cfg),
    .has_marker(has_marker), .fifo_empty(empty),
    .head_data(head_data), .head_eoe(head_eoe),
    .grant_in(grant_in), .slv_rd(slv_rd),
    .pop(pop), .bus_req(bus_req), .bus_valid(bus_valid),
    .bus_data(bus_data), .bus_last(bus_last),
    .done(done), .err(err),
    .slv_rvalid(slv_rvalid), .slv_rdata(slv_rdata)
  );

  assign grant_out = grant_in & ~bus_req;

  assert_token_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !grant_out);
endmodule

// File: tb/evt_unload_master_test.sv
`timescale 1ns/1ps
module evt_unload_master_test;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 16;
  localparam int CNT_W  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_eoe = 1'b0, start_load = 1'b0, grant_in = 1'b0, slv_rd = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic [7:0] delay_cfg = '0, timeout_cfg = '0;
  logic in_ready, bus_req, grant_out, bus_valid, bus_last, done, err, slv_rvalid;
  logic [DATA_W-1:0] bus_data, slv_rdata;

  always #4 clk = ~clk;

  evt_unload_master uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_eoe(in_eoe), .start_load(start_load),
    .delay_cfg(delay_cfg), .timeout_cfg(timeout_cfg), .bus_req(bus_req),
    .grant_in(grant_in), .grant_out(grant_out), .bus_valid(bus_valid),
    .bus_data(bus_data), .bus_last(bus_last), .done(done), .err(err),
    .slv_rd(slv_rd), .slv_rvalid(slv_rvalid), .slv_rdata(slv_rdata)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase 0 idle, 1 delay, 2 look for data, 3 request, 4 header, 5 burst
  int ph, dc, tc, evc;
  bit m_tmo, m_done, m_err, m_rv;
  logic [DATA_W-1:0] m_rd;
  logic [DATA_W:0] q[$];

  always @(posedge clk) begin : model
    bit has_m, do_push, sok, fin;
    logic [DATA_W:0] nw;
    if (!rst_n) begin
      ph = 0; dc = 0; tc = 0; evc = 0; m_tmo = 0; m_done = 0; m_err = 0;
      m_rv = 0; m_rd = '0; q.delete();
    end else begin
      has_m = 0;
      foreach (q[i]) if (q[i][DATA_W]) has_m = 1;
      do_push = in_valid && (q.size() < DEPTH);
      nw = {in_eoe, in_data};
      sok = slv_rd && ph == 0 && !start_load;
      fin = 0;
      m_rv = sok;
      m_rd = '0;
      if (sok && q.size() > 0) begin m_rd = q[0][DATA_W-1:0]; void'(q.pop_front()); end
      case (ph)
        0: if (start_load) begin m_done = 0; m_err = 0; dc = delay_cfg; ph = 1; end
        1: if (dc == 0) begin ph = 2; tc = 0; end else dc--;
        2: if (has_m) begin m_tmo = 0; ph = 3; end
           else if (tc == timeout_cfg) begin m_tmo = 1; ph = 3; end
           else tc++;
        3: if (grant_in) ph = 4;
        4: if (m_tmo) fin = 1; else ph = 5;
        5: begin if (q[0][DATA_W]) fin = 1; void'(q.pop_front()); end
        default: ph = 0;
      endcase
      if (fin) begin ph = 0; m_done = 1; m_err = m_tmo; evc = (evc + 1) % (1 << CNT_W); end
      if (do_push) q.push_back(nw);
    end
  end

  always @(negedge clk) begin : compare
    bit e_req, e_val;
    if (rst_n) begin
      e_req = (ph >= 3);
      e_val = (ph >= 4);
      chk("R1 in_ready", in_ready, q.size() < DEPTH);
      chk("R3 R4 bus_req", bus_req, e_req);
      chk("R5 grant_out", grant_out, grant_in & !e_req);
      chk("R6 bus_valid", bus_valid, e_val);
      if (ph == 4) begin
        chk("R9 header", bus_data, evc);
        chk("R8 header last", bus_last, m_tmo);
      end
      if (ph == 5) begin
        chk("R6 R1 burst data", bus_data, q[0][DATA_W-1:0]);
        chk("R6 burst last", bus_last, q[0][DATA_W]);
      end
      chk("R2 R7 done", done, m_done);
      chk("R8 err", err, m_err);
      chk("R10 rvalid", slv_rvalid, m_rv);
      chk("R10 rdata", slv_rdata, m_rd);
    end
  end

  task automatic step(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask
  task automatic push(logic [DATA_W-1:0] d, logic e);
    in_valid = 1; in_data = d; in_eoe = e; step(1); in_valid = 0; in_eoe = 0;
  endtask
  task automatic load(int d, int t);
    delay_cfg = 8'(d); timeout_cfg = 8'(t); start_load = 1; step(1); start_load = 0;
  endtask
  task automatic sread();
    slv_rd = 1; step(1); slv_rd = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(4);
    chk("R7 reset done", done, 0);
    chk("R4 reset req", bus_req, 0);
    chk("R1 reset ready", in_ready, 1);
    rst_n = 1;
    step(1);
    // basic event, grant always present
    grant_in = 1;
    push(16'h0a01, 0); push(16'h0a02, 0); push(16'h0a03, 0); push(16'h0aff, 1);
    load(2, 20); step(15);
    // data arrives late, grant delayed
    grant_in = 0;
    load(0, 30); step(3);
    push(16'h0b01, 0); push(16'h0bff, 1); step(4);
    grant_in = 1; step(1); grant_in = 0; step(8);
    // timeout with partial record, then slave drain incl. empty read
    grant_in = 1;
    push(16'h0c01, 0); push(16'h0c02, 0);
    load(1, 5); step(15);
    sread(); sread(); sread(); step(2);
    // load command while busy is ignored
    grant_in = 0;
    push(16'h0d01, 0); push(16'h0dff, 1);
    load(3, 10); step(2); load(0, 0); step(8);
    grant_in = 1; step(6);
    // buffer full, then burst, slave read while busy ignored
    in_valid = 1;
    for (int i = 0; i < 20; i++) begin in_data = 16'(16'h0e00 + i); in_eoe = (i == 10); step(1); end
    in_valid = 0; in_eoe = 0;
    load(0, 10); step(3); sread(); step(14);
    repeat (6) sread();
    step(2);
    // back-to-back events, counter stepping
    push(16'h0f01, 1); push(16'h0f02, 0); push(16'h0f03, 1);
    load(0, 10); step(8); load(1, 10); step(10);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule